// File: doc/BRIEF.md
# Extended Interrupt Vector Router

This block collects a wide set of level-style interrupt inputs and turns them into per-core CPU interrupt lines. Each input vector is gated by its own enable bit. When an enabled vector is high, a sticky status bit is set in the status bank of one target core. The vectors are split into groups of 32, and each group is assigned to one of eight CPU interrupt lines. Every CPU line of every core is the OR of that core's status bits over all vectors whose group points at that line.

Software reaches the block through a simple register bus with byte addresses and 4-byte or 8-byte accesses. It sets the line of each group with a group byte. It picks the target core of each vector with a per-vector steering byte. The upper nibble of that byte carries a node type, which is stored and read back. The lower nibble is a core mask, and only its lowest set bit is honoured, because requests are never spread over several cores. Software acknowledges a vector by writing ones into the status bank of the core that owns it. One node of four cores is modelled.

Top module: `irqRouter`

## Requirements
- R1: After reset, every CPU line is low, every enable bit reads 1, every group byte reads 0x00, every steering byte reads 0x01 (core 0), and every status bit reads 0.
- R2: An input vector that is high and enabled at a rising clock edge sets the status bit of its target core at that edge. The matching CPU line is high right after that edge and stays high after the input falls, until software clears the bit.
- R3: The enable bank holds one bit per vector at byte offset 0x1600 (vector v at byte v/8, bit v%8). A vector whose enable bit is 0 never sets a status bit and never raises a line.
- R4: The group byte of group g sits at byte offset 0x14C0+g. Its bits 2:0 select the CPU line (0 to 7) for vectors 32g to 32g+31. Bits 7:3 are dropped on write and read back as 0.
- R5: The steering byte of vector v sits at byte offset 0x1C00+v. The target core is the lowest set bit among bits 3:0. A mask of zero selects core 0. Bits 7:4 (node type) are stored and read back but do not affect steering.
- R6: The status bank of core c sits at byte offset 0x1800+32c, with vector v at byte v/8, bit v%8. Writing 1 clears a bit and writing 0 leaves it unchanged. If the vector is still high and enabled in the same cycle, the bit stays set.
- R7: The CPU line output bit c*8+l is the OR of core c's status bits over all vectors whose group selects line l. Changing a group byte moves pending status to the newly selected line.
- R8: Size code 2'b10 is a 4-byte access and 2'b11 is an 8-byte access. The address is aligned down to the access size, and the lowest address maps to data bits 7:0. Writes with any other size code change nothing, and reads with any other size code return zero.
- R9: Every read returns its data on the read-data port, with the read-valid flag high, in the cycle after the request. Bytes at unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Register access request this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 16 | Byte address of the access |
| busSize | input | 2 | Access size code (2'b10 = 4 bytes, 2'b11 = 8 bytes) |
| busWdata | input | 64 | Write data, little-endian byte lanes |
| rdValid | output | 1 | Read data valid, one cycle after a read request |
| rdData | output | 64 | Read data |
| irqIn | input | 256 | Level interrupt inputs, one per vector |
| cpuIrq | output | 32 | CPU interrupt lines, bit core*8+line |

## Verification
The assertions assume that a CPU line can only rise after an input was high or after a register write, and can only fall after a register write. They also assume that the bus raises at most one request per cycle. The stimulus respects this by driving inputs and bus fields only between clock edges, and by issuing each access as a single-cycle request followed by an idle cycle. The sweep pulses one vector at a time and clears it before the next one, so every observed line is caused by exactly one known vector, apart from the directed cases that deliberately overlap two vectors.

// File: rtl/irqRouterPkg.sv
package irqRouterPkg;

  localparam int ADDR_W = 16;

  // Byte offsets of the register regions
  localparam int ROUTE_BASE = 'h14C0;
  localparam int EN_BASE    = 'h1600;
  localparam int STAT_BASE  = 'h1800;
  localparam int MAP_BASE   = 'h1C00;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_ROUTE,
    RGN_EN,
    RGN_STAT,
    RGN_MAP
  } region_e;

  // Strobes from bus control to datapath
  typedef struct packed {
    logic              wr;
    logic              rd;
    logic              wide;
    region_e           region;
    logic [ADDR_W-1:0] offs;
  } strobe_t;

endpackage

// File: rtl/irqRegCtrl.sv
module irqRegCtrl
  import irqRouterPkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int NUM_CORES  = 4,
  parameter int GROUP_SIZE = 32
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  output strobe_t           stb
);

  localparam int VEC_BYTES  = NUM_VEC / 8;
  localparam int ROUTE_SPAN = NUM_VEC / GROUP_SIZE;
  localparam int STAT_SPAN  = VEC_BYTES * NUM_CORES;

  logic              legal;
  logic              wide;
  logic [ADDR_W-1:0] base;
  int                baseI;

  always_comb begin
    legal = busValid && busSize[1];
    wide  = busSize[0];
    base  = busAddr & ~(wide ? ADDR_W'(7) : ADDR_W'(3));
    baseI = int'(base);
    stb        = '0;
    stb.rd     = busValid && !busWrite;
    stb.wide   = wide;
    stb.region = RGN_NONE;
    if (legal) begin
      if (baseI >= ROUTE_BASE && baseI < ROUTE_BASE + ROUTE_SPAN) begin
        stb.region = RGN_ROUTE;
        stb.offs   = ADDR_W'(baseI - ROUTE_BASE);
      end else if (baseI >= EN_BASE && baseI < EN_BASE + VEC_BYTES) begin
        stb.region = RGN_EN;
        stb.offs   = ADDR_W'(baseI - EN_BASE);
      end else if (baseI >= STAT_BASE && baseI < STAT_BASE + STAT_SPAN) begin
        stb.region = RGN_STAT;
        stb.offs   = ADDR_W'(baseI - STAT_BASE);
      end else if (baseI >= MAP_BASE && baseI < MAP_BASE + NUM_VEC) begin
        stb.region = RGN_MAP;
        stb.offs   = ADDR_W'(baseI - MAP_BASE);
      end
    end
    stb.wr = legal && busWrite && (stb.region != RGN_NONE);
  end

endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqRouterPkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int NUM_CORES  = 4,
  parameter int NUM_LINES  = 8,
  parameter int GROUP_SIZE = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [63:0]                    wdata,
  input  logic [NUM_VEC-1:0]             irqIn,
  output logic                           rdValid,
  output logic [63:0]                    rdData,
  output logic [NUM_CORES*NUM_LINES-1:0] cpuIrq
);

  localparam int NUM_GROUPS = NUM_VEC / GROUP_SIZE;
  localparam int LINE_W     = $clog2(NUM_LINES);
  localparam int VEC_BYTES  = NUM_VEC / 8;

  logic [NUM_VEC-1:0]                   enQ;
  logic [NUM_GROUPS-1:0][LINE_W-1:0]    routeQ;
  logic [NUM_VEC-1:0][7:0]              mapQ;
  logic [NUM_CORES-1:0][NUM_VEC-1:0]    statQ;

  logic [NUM_CORES-1:0][NUM_VEC-1:0]    setVec;
  logic [NUM_CORES-1:0][NUM_VEC-1:0]    clrVec;
  logic [NUM_VEC-1:0][NUM_CORES-1:0]    tgt;
  logic [NUM_LINES-1:0][NUM_VEC-1:0]    lineMask;
  logic [7:0]                           laneOn;
  int                                   byteIdx [8];
  int                                   coreSel [8];
  int                                   coreByte [8];
  logic [63:0]                          rdNext;

  // Byte lanes of the current access
  always_comb begin
    for (int k = 0; k < 8; k++) begin
      laneOn[k]   = (k < 4) || stb.wide;
      byteIdx[k]  = int'(stb.offs) + k;
      coreSel[k]  = byteIdx[k] / VEC_BYTES;
      coreByte[k] = byteIdx[k] % VEC_BYTES;
    end
  end

  // Target core: lowest set mask bit, core 0 when the mask is empty
  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      tgt[v] = '0;
      for (int c = NUM_CORES - 1; c >= 0; c--) begin
        if (mapQ[v][c]) tgt[v] = NUM_CORES'(1) << c;
      end
      if (tgt[v] == '0) tgt[v][0] = 1'b1;
      for (int c = 0; c < NUM_CORES; c++) begin
        setVec[c][v] = irqIn[v] && enQ[v] && tgt[v][c];
      end
    end
  end

  // Write-one-to-clear vector
  always_comb begin
    clrVec = '0;
    if (stb.wr && stb.region == RGN_STAT) begin
      for (int k = 0; k < 8; k++) begin
        if (laneOn[k] && coreSel[k] < NUM_CORES)
          clrVec[coreSel[k]][coreByte[k]*8 +: 8] = wdata[k*8 +: 8];
      end
    end
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= '1;
      routeQ <= '0;
      for (int v = 0; v < NUM_VEC; v++) mapQ[v] <= 8'h01;
    end else if (stb.wr) begin
      for (int k = 0; k < 8; k++) begin
        if (laneOn[k]) begin
          case (stb.region)
            RGN_EN:    if (byteIdx[k] < VEC_BYTES)
                         enQ[byteIdx[k]*8 +: 8] <= wdata[k*8 +: 8];
            RGN_ROUTE: if (byteIdx[k] < NUM_GROUPS)
                         routeQ[byteIdx[k]] <= wdata[k*8 +: LINE_W];
            RGN_MAP:   if (byteIdx[k] < NUM_VEC)
                         mapQ[byteIdx[k]] <= wdata[k*8 +: 8];
            default: ;
          endcase
        end
      end
    end
  end

  // Sticky status, set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrVec) | setVec;
  end

  // Read mux
  always_comb begin
    rdNext = '0;
    if (stb.rd) begin
      for (int k = 0; k < 8; k++) begin
        if (laneOn[k]) begin
          case (stb.region)
            RGN_EN:    if (byteIdx[k] < VEC_BYTES)
                         rdNext[k*8 +: 8] = enQ[byteIdx[k]*8 +: 8];
            RGN_ROUTE: if (byteIdx[k] < NUM_GROUPS)
                         rdNext[k*8 +: 8] = 8'(routeQ[byteIdx[k]]);
            RGN_STAT:  if (coreSel[k] < NUM_CORES)
                         rdNext[k*8 +: 8] = statQ[coreSel[k]][coreByte[k]*8 +: 8];
            RGN_MAP:   if (byteIdx[k] < NUM_VEC)
                         rdNext[k*8 +: 8] = mapQ[byteIdx[k]];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rd;
      rdData  <= rdNext;
    end
  end

  // Line aggregation
  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        lineMask[l][v] = (routeQ[v / GROUP_SIZE] == LINE_W'(l));
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    for (genvar l = 0; l < NUM_LINES; l++) begin : gLine
      assign cpuIrq[c*NUM_LINES + l] = |(statQ[c] & lineMask[l]);
    end
  end

endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irqRouterPkg::*;
#(
  parameter int NUM_VEC    = 256,
  parameter int NUM_CORES  = 4,
  parameter int NUM_LINES  = 8,
  parameter int GROUP_SIZE = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           busValid,
  input  logic                           busWrite,
  input  logic [15:0]                    busAddr,
  input  logic [1:0]                     busSize,
  input  logic [63:0]                    busWdata,
  output logic                           rdValid,
  output logic [63:0]                    rdData,
  input  logic [NUM_VEC-1:0]             irqIn,
  output logic [NUM_CORES*NUM_LINES-1:0] cpuIrq
);

  strobe_t stb;

  irqRegCtrl #(
    .NUM_VEC(NUM_VEC), .NUM_CORES(NUM_CORES), .GROUP_SIZE(GROUP_SIZE)
  ) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .stb(stb)
  );

  irqDatapath #(
    .NUM_VEC(NUM_VEC), .NUM_CORES(NUM_CORES),
    .NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE)
  ) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wdata(busWdata), .irqIn(irqIn),
    .rdValid(rdValid), .rdData(rdData), .cpuIrq(cpuIrq)
  );

endmodule

// File: rtl/irqRouterChk.sv
module irqRouterChk #(
  parameter int NUM_VEC   = 256,
  parameter int OUT_W     = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               busValid,
  input logic               busWrite,
  input logic [1:0]         busSize,
  input logic [NUM_VEC-1:0] irqIn,
  input logic               rdValid,
  input logic [63:0]        rdData,
  input logic [OUT_W-1:0]   cpuIrq
);

  // R9
  rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rdValid);

  // R9
  rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !rdValid);

  // R8
  bad_size_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && !busSize[1]) |=> (rdData == '0));

  // R6
  line_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(~cpuIrq & $past(cpuIrq))) |-> $past(busValid && busWrite));

  // R2
  line_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(cpuIrq & ~$past(cpuIrq))) |-> ($past(|irqIn) || $past(busValid && busWrite)));

endmodule

bind irqRouter irqRouterChk #(
  .NUM_VEC(NUM_VEC), .OUT_W(NUM_CORES*NUM_LINES)
) uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busSize(busSize), .irqIn(irqIn), .rdValid(rdValid), .rdData(rdData),
  .cpuIrq(cpuIrq)
);

// File: tb/sim_irqRouter.sv
module sim_irqRouter;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busValid = 1'b0;
  logic         busWrite = 1'b0;
  logic [15:0]  busAddr = '0;
  logic [1:0]   busSize = 2'b10;
  logic [63:0]  busWdata = '0;
  logic         rdValid;
  logic [63:0]  rdData;
  logic [255:0] irqIn = '0;
  logic [31:0]  cpuIrq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irqRouter u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .rdValid(rdValid), .rdData(rdData), .irqIn(irqIn), .cpuIrq(cpuIrq)
  );

  function automatic int lineOf(int g);
    return (g * 3 + 1) % 8;
  endfunction

  function automatic logic [7:0] mapOf(int v);
    return {4'(v % 16), 4'((v % 15) + 1)};
  endfunction

  function automatic int lowCore(logic [7:0] m);
    for (int c = 0; c < 4; c++) if (m[c]) return c;
    return 0;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWr(int addr, logic [1:0] size, logic [63:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 16'(addr);
    busSize = size; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(int addr, logic [1:0] size, output logic [63:0] data,
                       output logic valid);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = 16'(addr); busSize = size;
    @(negedge clk);
    data = rdData; valid = rdValid;
    busValid = 1'b0;
  endtask

  task automatic rdChk(string req, int addr, logic [1:0] size, logic [63:0] exp);
    logic [63:0] d;
    logic vld;
    busRd(addr, size, d, vld);
    chk({req, " valid"}, 64'(vld), 64'd1);
    chk(req, d, exp);
  endtask

  task automatic pulse(int v);
    @(negedge clk);
    irqIn[v] = 1'b1;
    @(negedge clk);
    irqIn[v] = 1'b0;
  endtask

  task automatic lineChk(string req, logic [31:0] exp);
    chk(req, 64'(cpuIrq), 64'(exp));
  endtask

  initial begin
    logic [63:0] w;
    logic [63:0] d;
    logic vld;
    int core;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    lineChk("R1 lines", 32'h0);
    rdChk("R1 enable", 'h1600, 2'b11, '1);
    rdChk("R1 route", 'h14C0, 2'b11, 64'h0);
    rdChk("R1 map", 'h1CF8, 2'b11, 64'h0101010101010101);
    rdChk("R1 status", 'h1860, 2'b11, 64'h0);

    // R4 program groups with junk in bits 7:3
    w = '0;
    for (int g = 0; g < 8; g++) w[g*8 +: 8] = 8'(lineOf(g)) | 8'hA8;
    busWr('h14C0, 2'b11, w);
    w = '0;
    for (int g = 0; g < 8; g++) w[g*8 +: 8] = 8'(lineOf(g));
    rdChk("R4 route readback", 'h14C0, 2'b11, w);

    // R5 program steering bytes
    for (int q = 0; q < 32; q++) begin
      w = '0;
      for (int j = 0; j < 8; j++) w[j*8 +: 8] = mapOf(q*8 + j);
      busWr('h1C00 + q*8, 2'b11, w);
    end
    w = '0;
    for (int j = 0; j < 8; j++) w[j*8 +: 8] = mapOf(200 + j);
    rdChk("R5 map readback", 'h1C00 + 200, 2'b11, w);

    // R2 R4 R5 R6 R7 sweep of every vector
    for (int v = 0; v < 256; v++) begin
      core = lowCore(mapOf(v));
      pulse(v);
      lineChk("R2 sweep line", 32'(1) << (core*8 + lineOf(v/32)));
      rdChk("R6 sweep status", 'h1800 + core*32 + (v/64)*8, 2'b11,
            64'(1) << (v % 64));
      busWr('h1800 + core*32 + (v/32)*4, 2'b10, 64'(32'(1) << (v % 32)));
      lineChk("R6 sweep cleared", 32'h0);
    end

    // R3 disabled vector
    busWr('h1600, 2'b10, 64'hFFFF_FFFE);
    rdChk("R3 enable readback", 'h1600, 2'b10, 64'hFFFF_FFFE);
    pulse(0);
    lineChk("R3 disabled line", 32'h0);
    rdChk("R3 disabled status", 'h1800, 2'b10, 64'h0);
    busWr('h1600, 2'b11, '1);
    pulse(0);
    lineChk("R3 reenabled line", 32'(1) << lineOf(0));
    busWr('h1800, 2'b10, 64'h1);

    // R2 sticky after input falls (vector 40: core 0, line 4)
    @(negedge clk); irqIn[40] = 1'b1;
    repeat (3) @(negedge clk);
    irqIn[40] = 1'b0;
    repeat (3) @(negedge clk);
    lineChk("R2 sticky", 32'(1) << 4);
    busWr('h1804, 2'b10, 64'h0);
    lineChk("R6 zero write keeps", 32'(1) << 4);
    @(negedge clk); irqIn[40] = 1'b1;
    busWr('h1804, 2'b10, 64'(32'(1) << 8));
    lineChk("R6 set wins", 32'(1) << 4);
    @(negedge clk); irqIn[40] = 1'b0;
    busWr('h1804, 2'b10, 64'(32'(1) << 8));
    lineChk("R6 cleared", 32'h0);

    // R7 OR of two vectors on core 0 line 7 (vectors 64 and 79)
    pulse(64);
    pulse(79);
    lineChk("R7 both", 32'(1) << 7);
    busWr('h1808, 2'b10, 64'h1);
    lineChk("R7 one left", 32'(1) << 7);
    w = '0;
    for (int g = 0; g < 4; g++) w[g*8 +: 8] = 8'(lineOf(g));
    w[16 +: 8] = 8'd1;
    busWr('h14C0, 2'b10, w);
    lineChk("R7 moved line", 32'(1) << 1);
    w[16 +: 8] = 8'(lineOf(2));
    busWr('h14C0, 2'b10, w);
    busWr('h1808, 2'b10, 64'(32'(1) << 15));
    lineChk("R7 none left", 32'h0);

    // R5 mask corner cases on vectors 0..3 (group 0, line 1)
    busWr('h1C00, 2'b10, 64'h5A0F_2C30);
    rdChk("R5 node nibble kept", 'h1C00, 2'b10, 64'h5A0F_2C30);
    pulse(0);
    lineChk("R5 empty mask core0", 32'(1) << 1);
    busWr('h1800, 2'b10, 64'h1);
    pulse(1);
    lineChk("R5 mask 1100 core2", 32'(1) << 17);
    busWr('h1840, 2'b10, 64'h2);
    pulse(2);
    lineChk("R5 mask 1111 core0", 32'(1) << 1);
    busWr('h1800, 2'b10, 64'h4);
    pulse(3);
    lineChk("R5 mask 1010 core1", 32'(1) << 9);
    busWr('h1820, 2'b10, 64'h8);
    lineChk("R5 all cleared", 32'h0);

    // R8 alignment and illegal sizes
    busWr('h1C15, 2'b11, 64'h8877_6655_4433_2211);
    rdChk("R8 aligned low", 'h1C12, 2'b10, 64'h4433_2211);
    rdChk("R8 aligned high", 'h1C17, 2'b10, 64'h8877_6655);
    busWr('h14C0, 2'b01, '1);
    busWr('h14C0, 2'b00, '1);
    w = '0;
    for (int g = 0; g < 8; g++) w[g*8 +: 8] = 8'(lineOf(g));
    rdChk("R8 illegal write ignored", 'h14C0, 2'b11, w);
    rdChk("R8 illegal read zero", 'h14C0, 2'b00, 64'h0);
    rdChk("R8 illegal read zero 2B", 'h1600, 2'b01, 64'h0);

    // R9 unmapped reads and valid timing
    rdChk("R9 unmapped low", 'h0100, 2'b11, 64'h0);
    rdChk("R9 status gap", 'h1880, 2'b11, 64'h0);
    rdChk("R9 route tail", 'h14C8, 2'b10, 64'h0);
    @(negedge clk);
    chk("R9 idle valid", 64'(rdValid), 64'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule